// File: doc/BRIEF.md
# Double-Buffered DAC Code Latch Bank

This block keeps the 10-bit codes for a bank of 24 reference channels: 22 gamma outputs and 2 common-voltage outputs. Each channel has two stages. A pending stage takes the words written over the serial host port. A live stage drives the DAC code pins. Bit 15 of a host write word is a transfer flag. A word with the flag clear only changes its own pending stage. A word with the flag set moves every pending stage into the live stages on the same clock edge. A host can therefore stage a whole gamma curve and switch all channels together, for example at a frame boundary.

Two direct load paths go around the double buffer. The first is a non-volatile program write. The second is a per-channel acquire load that an OTP controller issues, one channel per cycle. Each path writes the pending and live stages of its target channel at once. The block also translates the linear pointer index into the physical pin order, because the two common-voltage channels sit in the middle of the pointer space.

Top module: `dac_latch_bank`

## Requirements
- R1: A host write to a valid pointer stores bits 9:0 of the word in that channel's pending stage. Bits 14:10 have no effect on the stored value.
- R2: A host write with bit 15 = 0 changes no live stage, so every output code stays the same.
- R3: A host write with bit 15 = 1 to a valid pointer copies all 24 pending stages into the live stages on the same clock edge that stores the word. The copied values include the word just written.
- R4: A program write stores bits 9:0 of its word in both stages of its channel on one edge. It does not transfer the pending stages of other channels.
- R5: An acquire load stores its 10-bit code in both stages of its channel on one edge.
- R6: Pointers 0 to 17 drive outputs 1 to 18, which are slices 0 to 17 of `out_codes`. Pointers 18 and 19 drive common-voltage channels 1 and 2, which are slices 0 and 1 of `vcom_codes`. Pointers 20 to 23 drive outputs 19 to 22, which are slices 18 to 21 of `out_codes`. Slice k occupies bits [10k+9:10k].
- R7: After reset, both stages of every channel hold 512.
- R8: The read port returns the pending stage of `rd_ptr`, zero-extended to 16 bits. A pointer of 24 or more reads 0.
- R9: When loads hit one channel in the same cycle, the acquire load wins over a program write, and a program write wins over a host write. The transfer flag of a host write still acts on the other channels.
- R10: A host write, program write or acquire load with a pointer of 24 or more changes nothing. This includes the transfer flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host word complete strobe |
| wr_ptr | input | 5 | Host write pointer |
| wr_data | input | 16 | Host word; bit 15 is the transfer flag, bits 9:0 are the code |
| prog_en | input | 1 | Program write strobe |
| prog_ptr | input | 5 | Program write pointer |
| prog_data | input | 16 | Program word; bits 9:0 are the code |
| acq_en | input | 1 | Acquire load strobe |
| acq_ptr | input | 5 | Acquire load pointer |
| acq_code | input | 10 | Acquired code |
| rd_ptr | input | 5 | Read pointer |
| rd_data | output | 16 | Pending stage of rd_ptr, zero-extended |
| out_codes | output | 220 | Live codes for outputs 1 to 22 |
| vcom_codes | output | 20 | Live codes for common-voltage channels 1 and 2 |

## Verification
The bench writes the transfer word together with staged words already sitting in other channels. A design that moved only the flagged channel, or that latched the old pending value of the flagged word, would show stale outputs there. It loads a distinct code into every pointer and checks each physical pin, which exposes any slip in the common-voltage remap around pointers 18 to 23. It also sends colliding acquire, program and flagged host writes in one cycle, and out-of-range pointers that carry the flag. A wrong priority order or an unguarded pointer would corrupt a channel or fire a transfer that should not happen.

// File: rtl/dlb_pkg.sv
package dlb_pkg;
  // Physical output slot of a gamma pointer (pointers below the common-voltage
  // window keep their index, those above it close the gap).
  function automatic int gamma_slot(input int ptr, input int vbase, input int nvcom);
    return (ptr < vbase) ? ptr : ptr - nvcom;
  endfunction

  function automatic bit is_vcom(input int ptr, input int vbase, input int nvcom);
    return (ptr >= vbase) && (ptr < vbase + nvcom);
  endfunction
endpackage

// File: rtl/dlb_ptr_dec.sv
module dlb_ptr_dec #(
  parameter int NCH   = 24,
  parameter int PTR_W = 5
) (
  input  logic             en,
  input  logic [PTR_W-1:0] ptr,
  output logic             ok,
  output logic [NCH-1:0]   hit
);
  assign ok = en && (ptr < PTR_W'(NCH));
  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign hit[i] = en && (ptr == PTR_W'(i));
  end
endmodule

// File: rtl/dlb_chan.sv
module dlb_chan #(
  parameter int W          = 10,
  parameter int RESET_CODE = 512
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_code,
  input  logic         direct,
  input  logic         xfer,
  output logic [W-1:0] pend_q,
  output logic [W-1:0] live_q
);
  logic [W-1:0] pend_nxt;
  assign pend_nxt = ld ? ld_code : pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= W'(RESET_CODE);
      live_q <= W'(RESET_CODE);
    end else begin
      pend_q <= pend_nxt;
      if (xfer || direct) live_q <= pend_nxt;
    end
  end
endmodule

// File: rtl/dlb_out_map.sv
module dlb_out_map #(
  parameter int NCH       = 24,
  parameter int W         = 10,
  parameter int VCOM_BASE = 18,
  parameter int NVCOM     = 2,
  localparam int NOUT     = NCH - NVCOM
) (
  input  logic [NCH-1:0][W-1:0] live,
  output logic [NOUT*W-1:0]     out_codes,
  output logic [NVCOM*W-1:0]    vcom_codes
);
  for (genvar p = 0; p < NCH; p++) begin : g_map
    if (dlb_pkg::is_vcom(p, VCOM_BASE, NVCOM)) begin : g_vcom
      assign vcom_codes[(p-VCOM_BASE)*W +: W] = live[p];
    end else begin : g_gamma
      assign out_codes[dlb_pkg::gamma_slot(p, VCOM_BASE, NVCOM)*W +: W] = live[p];
    end
  end
endmodule

// File: rtl/dac_latch_bank.sv
module dac_latch_bank #(
  parameter int NCH        = 24,
  parameter int W          = 10,
  parameter int PTR_W      = 5,
  parameter int DATA_W     = 16,
  parameter int XFER_BIT   = 15,
  parameter int VCOM_BASE  = 18,
  parameter int NVCOM      = 2,
  parameter int RESET_CODE = 512,
  localparam int NOUT      = NCH - NVCOM
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_en,
  input  logic [PTR_W-1:0]  prog_ptr,
  input  logic [DATA_W-1:0] prog_data,
  input  logic              acq_en,
  input  logic [PTR_W-1:0]  acq_ptr,
  input  logic [W-1:0]      acq_code,
  input  logic [PTR_W-1:0]  rd_ptr,
  output logic [DATA_W-1:0] rd_data,
  output logic [NOUT*W-1:0] out_codes,
  output logic [NVCOM*W-1:0] vcom_codes
);
  logic [NCH-1:0] wr_hit, prog_hit, acq_hit;
  logic           wr_ok, prog_ok, acq_ok;
  logic           xfer_fire;
  logic [NCH-1:0][W-1:0] pend_q, live_q;

  dlb_ptr_dec #(.NCH(NCH), .PTR_W(PTR_W)) u_wr_dec (
    .en(wr_en), .ptr(wr_ptr), .ok(wr_ok), .hit(wr_hit));
  dlb_ptr_dec #(.NCH(NCH), .PTR_W(PTR_W)) u_prog_dec (
    .en(prog_en), .ptr(prog_ptr), .ok(prog_ok), .hit(prog_hit));
  dlb_ptr_dec #(.NCH(NCH), .PTR_W(PTR_W)) u_acq_dec (
    .en(acq_en), .ptr(acq_ptr), .ok(acq_ok), .hit(acq_hit));

  assign xfer_fire = wr_ok && wr_data[XFER_BIT];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic         ld, direct;
    logic [W-1:0] code;
    assign direct = acq_hit[i] || prog_hit[i];
    assign ld     = direct || wr_hit[i];
    assign code   = acq_hit[i]  ? acq_code :
                    prog_hit[i] ? prog_data[W-1:0] : wr_data[W-1:0];
    dlb_chan #(.W(W), .RESET_CODE(RESET_CODE)) u_chan (
      .clk(clk), .rst_n(rst_n), .ld(ld), .ld_code(code), .direct(direct),
      .xfer(xfer_fire), .pend_q(pend_q[i]), .live_q(live_q[i]));
  end

  assign rd_data = (rd_ptr < PTR_W'(NCH)) ? {{(DATA_W-W){1'b0}}, pend_q[rd_ptr]} : '0;

  dlb_out_map #(.NCH(NCH), .W(W), .VCOM_BASE(VCOM_BASE), .NVCOM(NVCOM)) u_map (
    .live(live_q), .out_codes(out_codes), .vcom_codes(vcom_codes));
endmodule

// File: rtl/dlb_checker.sv
module dlb_checker #(
  parameter int NCH      = 24,
  parameter int W        = 10,
  parameter int PTR_W    = 5,
  parameter int DATA_W   = 16,
  parameter int XFER_BIT = 15
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [PTR_W-1:0]      wr_ptr,
  input logic [DATA_W-1:0]     wr_data,
  input logic                  prog_en,
  input logic [PTR_W-1:0]      prog_ptr,
  input logic [DATA_W-1:0]     prog_data,
  input logic                  acq_en,
  input logic [PTR_W-1:0]      acq_ptr,
  input logic [W-1:0]          acq_code,
  input logic                  wr_ok,
  input logic                  prog_ok,
  input logic                  acq_ok,
  input logic                  xfer_fire,
  input logic [NCH-1:0][W-1:0] pend_q,
  input logic [NCH-1:0][W-1:0] live_q
);
  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((1 << W) - 1);

  assert_wr_low_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && !prog_ok && !acq_ok |=>
      {{(DATA_W-W){1'b0}}, pend_q[$past(wr_ptr)]} == ($past(wr_data) & LOW_MASK));

  assert_wr_holds_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && !wr_data[XFER_BIT] && !prog_ok && !acq_ok |=> $stable(live_q));

  assert_xfer_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fire |=> live_q == pend_q);

  assert_prog_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_ok && !(acq_ok && acq_ptr == prog_ptr) |=>
      ({{(DATA_W-W){1'b0}}, live_q[$past(prog_ptr)]} == ($past(prog_data) & LOW_MASK)) &&
      (pend_q[$past(prog_ptr)] == live_q[$past(prog_ptr)]));

  assert_acq_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acq_ok |=> pend_q[$past(acq_ptr)] == $past(acq_code) &&
               live_q[$past(acq_ptr)] == $past(acq_code));

  assert_bad_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_ok && !prog_en && !acq_en |=> $stable(pend_q) && $stable(live_q));
endmodule

bind dac_latch_bank dlb_checker #(
  .NCH(NCH), .W(W), .PTR_W(PTR_W), .DATA_W(DATA_W), .XFER_BIT(XFER_BIT)
) u_dlb_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data),
  .prog_en(prog_en), .prog_ptr(prog_ptr), .prog_data(prog_data),
  .acq_en(acq_en), .acq_ptr(acq_ptr), .acq_code(acq_code),
  .wr_ok(wr_ok), .prog_ok(prog_ok), .acq_ok(acq_ok), .xfer_fire(xfer_fire),
  .pend_q(pend_q), .live_q(live_q));

// File: tb/test_dac_latch_bank.sv
`timescale 1ns/1ps
module test_dac_latch_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0, prog_en = 0, acq_en = 0;
  logic [4:0]  wr_ptr = 0, prog_ptr = 0, acq_ptr = 0, rd_ptr = 0;
  logic [15:0] wr_data = 0, prog_data = 0;
  logic [9:0]  acq_code = 0;
  logic [15:0] rd_data;
  logic [219:0] out_codes;
  logic [19:0]  vcom_codes;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  int ref_pend [24];
  int ref_live [24];

  always #2.5 clk = ~clk;

  dac_latch_bank i_dac_latch_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ptr(wr_ptr), .wr_data(wr_data),
    .prog_en(prog_en), .prog_ptr(prog_ptr), .prog_data(prog_data),
    .acq_en(acq_en), .acq_ptr(acq_ptr), .acq_code(acq_code),
    .rd_ptr(rd_ptr), .rd_data(rd_data), .out_codes(out_codes), .vcom_codes(vcom_codes));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pin order restated independently: outputs 1..18 <- ptr 0..17, 19..22 <- ptr 20..23.
  task automatic check_pins(input string req);
    for (int k = 1; k <= 22; k++) begin
      int p;
      p = (k <= 18) ? k - 1 : k + 1;
      check($sformatf("%s out%0d", req, k), int'(out_codes[(k-1)*10 +: 10]), ref_live[p]);
    end
    for (int j = 0; j < 2; j++)
      check($sformatf("%s vcom%0d", req, j+1), int'(vcom_codes[j*10 +: 10]), ref_live[18+j]);
  endtask

  task automatic check_reads(input string req);
    for (int p = 0; p < 24; p++) begin
      rd_ptr = 5'(p);
      #0.1;
      check($sformatf("%s rd%0d", req, p), int'(rd_data), ref_pend[p]);
    end
  endtask

  // One clock of stimulus; model follows the requirement text.
  task automatic step(input bit we, input int wp, input int wd,
                      input bit pe, input int pp, input int pd,
                      input bit ae, input int ap, input int ac);
    wr_en = we; wr_ptr = 5'(wp); wr_data = 16'(wd);
    prog_en = pe; prog_ptr = 5'(pp); prog_data = 16'(pd);
    acq_en = ae; acq_ptr = 5'(ap); acq_code = 10'(ac);
    @(posedge clk);
    begin
      bit direct [24];
      for (int i = 0; i < 24; i++) direct[i] = 0;
      if (we && wp < 24) ref_pend[wp] = wd & 'h3FF;
      if (pe && pp < 24) begin ref_pend[pp] = pd & 'h3FF; direct[pp] = 1; end
      if (ae && ap < 24) begin ref_pend[ap] = ac; direct[ap] = 1; end
      for (int i = 0; i < 24; i++)
        if ((we && wp < 24 && wd[15]) || direct[i]) ref_live[i] = ref_pend[i];
    end
    @(negedge clk);
    wr_en = 0; prog_en = 0; acq_en = 0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 24; i++) begin ref_pend[i] = 512; ref_live[i] = 512; end
    check_pins("R7 reset");
    check_reads("R7 reset");
  endtask

  task automatic t_stage_only;
    step(1, 3, 'h7D55, 0,0,0, 0,0,0);   // bits 14:10 set, bit 15 clear
    check_pins("R2 staged");
    rd_ptr = 3; #0.1;
    check("R1 low bits stored", int'(rd_data), 'h155);
    check("R8 zero-extended", int'(rd_data[15:10]), 0);
  endtask

  task automatic t_transfer;
    step(1, 21, 'h0300, 0,0,0, 0,0,0);
    check_pins("R2 second staged");
    step(1, 5, 'h8000 | 77, 0,0,0, 0,0,0);
    check_pins("R3 global transfer");
    check("R3 staged ch3 live", int'(out_codes[3*10 +: 10]), 'h155);
    check("R3 own word live", int'(out_codes[5*10 +: 10]), 77);
  endtask

  task automatic t_map;
    for (int p = 0; p < 24; p++) step(1, p, 100 + 37*p, 0,0,0, 0,0,0);
    check_pins("R2 map staged");
    step(1, 23, 'h8000 | 999, 0,0,0, 0,0,0);
    check_pins("R6 mapping");
    check("R6 vcom1", int'(vcom_codes[9:0]), 100 + 37*18);
    check("R6 out19", int'(out_codes[18*10 +: 10]), 100 + 37*20);
    check_reads("R8 map read");
  endtask

  task automatic t_prog;
    step(1, 11, 444, 0,0,0, 0,0,0);
    step(0,0,0, 1, 10, 'hFC00 | 321, 0,0,0);
    check_pins("R4 program");
    check("R4 out11 live", int'(out_codes[10*10 +: 10]), 321);
    check("R4 no transfer ch11", int'(out_codes[11*10 +: 10]), ref_live[11]);
    check_reads("R4 program read");
  endtask

  task automatic t_acq;
    step(0,0,0, 0,0,0, 1, 19, 606);
    check("R5 vcom2 live", int'(vcom_codes[19:10]), 606);
    rd_ptr = 19; #0.1;
    check("R5 vcom2 pending", int'(rd_data), 606);
    check_pins("R5 acquire");
  endtask

  task automatic t_collide;
    step(1, 2, 500, 0,0,0, 0,0,0);
    step(1, 7, 'h8000 | 11, 1, 7, 22, 1, 7, 33);
    check("R9 acquire wins", int'(out_codes[7*10 +: 10]), 33);
    check("R9 flag still moves ch2", int'(out_codes[2*10 +: 10]), 500);
    step(1, 8, 55, 1, 8, 66, 0,0,0);
    check("R9 program beats write", int'(out_codes[8*10 +: 10]), 66);
    check_pins("R9 collide");
    check_reads("R9 collide read");
  endtask

  task automatic t_bad_ptr;
    step(1, 4, 808, 0,0,0, 0,0,0);
    step(1, 26, 'h8000 | 1, 0,0,0, 0,0,0);
    check_pins("R10 flagged bad pointer");
    step(0,0,0, 1, 30, 2, 1, 24, 3);
    check_pins("R10 bad direct loads");
    check_reads("R10 reads");
    rd_ptr = 27; #0.1;
    check("R8 out-of-range read", int'(rd_data), 0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_stage_only();
    t_transfer();
    t_map();
    t_prog();
    t_acq();
    t_collide();
    t_bad_ptr();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule